// File: doc/BRIEF.md
# Hidden Address Latch Tracker

This block keeps a shadow copy of the 16-bit internal address latch found in a classic 8-bit CPU core. Software cannot read this latch directly. It still shows up in two places: in flag bits 5 and 3 after a bit test on a memory operand, and in the contents that a cycle-exact model must reproduce. A core or an emulation harness drives the block with every instruction as it retires. For each one it supplies the prefix class, the opcode, the immediate word and the register values the instruction used. The block then applies the update rule that belongs to that opcode.

Each rule takes one of the following forms:
- an operand address plus one;
- the accumulator packed with the low byte of an address plus one;
- a branch target;
- a restart vector;
- the immediate word;
- a step up or down for the block compare instructions;
- no change.

A host preset port loads the latch directly, for example when a saved machine state is restored. The flag-leak output is combinational. It is valid for the instruction being presented, and it uses the latch value held before that instruction retires.

Top module: `hidden_latch_tracker`

## Requirements
- R1: Synchronous active-high reset sets the latch to 16'hFFFF.
- R2: When `preset_we` is high, the latch takes `preset_val` at the next edge, even if `retire` is high in the same cycle. When neither is high, the latch holds.
- R3: Prefix code `pfx` is 0 = none, 1 = ED page, 2 = CB page, 3 = DD, 4 = FD, 5 = indexed bit page (DD CB / FD CB). Unprefixed 0A, 1A and 3A set the latch to BC+1, DE+1 and imm+1 respectively, wrapping modulo 65536.
- R4: Unprefixed 02, 12 and 32 set the latch high byte to `acc`. They set the low byte to the low byte of (BC+1), (DE+1) or (imm+1) respectively.
- R5: Unprefixed 22 and 2A, ED-page 43/4B/53/5B/63/6B/73/7B, and DD/FD 22 and 2A set the latch to imm+1.
- R6: Unprefixed 09/19/29/39, ED-page 42/4A/52/5A/62/6A/72/7A, and ED-page 67 and 6F set the latch to `hl` + 1, where `hl` is the value before the instruction.
- R7: ED-page 78 and 79 set the latch to BC+1.
- R8: ED-page A1 and B1 add one to the latch. ED-page A9 and B9 subtract one, with wrap.
- R9: Unprefixed 10, 18, 20, 28, 30, 38 and C9, and ED-page 4D, set the latch to `new_pc`, whether or not a condition was met.
- R10: An unprefixed opcode of the form 11xxx111 sets the latch to the restart vector, opcode bits 5:3 times 8.
- R11: Unprefixed C3, CD, and any 11xxx010 or 11xxx100 opcode set the latch to imm, whatever the condition. Opcode E9 leaves the latch unchanged under every prefix.
- R12: `leak53[1]` is flag 5 and `leak53[0]` is flag 3. These bits are valid when the presented instruction is a bit test: a CB-page opcode 01xxxxxx, or any prefix-5 opcode 01xxxxxx. For a memory operand (CB page with opcode bits 2:0 = 6, or prefix 5), they equal latch bits 13 and 11. For a register operand, they equal `bit_operand` bits 5 and 3. For any other instruction they are 00.
- R13: Every other opcode leaves the latch unchanged, whatever its operand inputs are. This covers all CB-page and prefix-5 opcodes, and any cycle in which `retire` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| retire | input | 1 | Strobe: the presented instruction retires this cycle |
| pfx | input | 3 | Prefix class code (see R3) |
| opcode | input | 8 | Opcode byte following the prefix |
| imm | input | 16 | Immediate word nn |
| acc | input | 8 | Accumulator value |
| bc | input | 16 | BC register pair |
| de | input | 16 | DE register pair |
| hl | input | 16 | HL before the instruction |
| new_pc | input | 16 | Program counter after the instruction |
| bit_operand | input | 8 | Register value tested by a register bit test |
| preset_we | input | 1 | Host preset write enable |
| preset_val | input | 16 | Host preset value |
| latch | output | 16 | Current latch value |
| leak53 | output | 2 | Flag bits 5 and 3 for a bit test |

## Verification
If the latch holds a wrong value, `latch` shows it on the clock edge after the retire that caused it. The error then persists until a rule overwrites the latch completely. Relative rules (block compare steps) and no-change opcodes carry an earlier error forward indefinitely. A wrong value also reaches `leak53` during the same cycle that the next memory bit test is presented. The tests therefore check the latch one cycle after each retire. They also run step and no-change opcodes from a preset value, so that a dropped or spurious update stays visible.

// File: rtl/hlt_pkg.sv
`timescale 1ns/1ps
package hlt_pkg;

    parameter int ADDR_W = 16;
    parameter int DATA_W = 8;
    parameter int PFX_W  = 3;

    localparam logic [ADDR_W-1:0] LATCH_RESET = {ADDR_W{1'b1}};
    localparam int FLAG_HI_POS = 5;
    localparam int FLAG_LO_POS = 3;
    localparam logic [DATA_W-1:0] FLAG_HI_MASK = DATA_W'(1) << FLAG_HI_POS;
    localparam logic [DATA_W-1:0] FLAG_LO_MASK = DATA_W'(1) << FLAG_LO_POS;
    localparam logic [ADDR_W-1:0] LATCH_HI_MASK = ADDR_W'(FLAG_HI_MASK) << DATA_W;
    localparam logic [ADDR_W-1:0] LATCH_LO_MASK = ADDR_W'(FLAG_LO_MASK) << DATA_W;

    typedef enum logic [PFX_W-1:0] {
        PFX_NONE  = 3'd0,
        PFX_ED    = 3'd1,
        PFX_CB    = 3'd2,
        PFX_DD    = 3'd3,
        PFX_FD    = 3'd4,
        PFX_IDXCB = 3'd5
    } pfx_e;

    typedef enum logic [2:0] {
        RL_KEEP,
        RL_PLUS1,
        RL_ACCHI,
        RL_BRANCH,
        RL_RST,
        RL_IMM,
        RL_UP,
        RL_DN
    } rule_e;

    typedef enum logic [1:0] {
        SRC_BC,
        SRC_DE,
        SRC_HL,
        SRC_IMM
    } src_e;

    typedef struct packed {
        rule_e      rule;
        src_e       src;
        logic [2:0] vec;
        logic       is_bit;
        logic       bit_mem;
    } dec_t;

    function automatic logic [ADDR_W-1:0] rst_vector(input logic [2:0] v);
        return ADDR_W'({v, 3'b000});
    endfunction

endpackage

// File: rtl/hlt_decode.sv
`timescale 1ns/1ps
module hlt_decode
    import hlt_pkg::*;
(
    input  logic [PFX_W-1:0]  pfx_i,
    input  logic [DATA_W-1:0] op_i,
    output dec_t              dec_o
);

    pfx_e pfx;
    assign pfx = pfx_e'(pfx_i);

    logic bit_page;
    assign bit_page = (op_i[7:6] == 2'b01);

    always_comb begin
        dec_o         = '0;
        dec_o.rule    = RL_KEEP;
        dec_o.src     = SRC_IMM;
        dec_o.vec     = op_i[5:3];
        dec_o.is_bit  = 1'b0;
        dec_o.bit_mem = 1'b0;
        case (pfx)
            PFX_NONE: begin
                case (op_i)
                    8'h0A: begin dec_o.rule = RL_PLUS1; dec_o.src = SRC_BC;  end
                    8'h1A: begin dec_o.rule = RL_PLUS1; dec_o.src = SRC_DE;  end
                    8'h3A: begin dec_o.rule = RL_PLUS1; dec_o.src = SRC_IMM; end
                    8'h02: begin dec_o.rule = RL_ACCHI; dec_o.src = SRC_BC;  end
                    8'h12: begin dec_o.rule = RL_ACCHI; dec_o.src = SRC_DE;  end
                    8'h32: begin dec_o.rule = RL_ACCHI; dec_o.src = SRC_IMM; end
                    8'h22, 8'h2A: begin dec_o.rule = RL_PLUS1; dec_o.src = SRC_IMM; end
                    8'h10, 8'h18, 8'h20, 8'h28, 8'h30, 8'h38, 8'hC9:
                        dec_o.rule = RL_BRANCH;
                    8'hC3, 8'hCD: dec_o.rule = RL_IMM;
                    default: begin
                        if (op_i[7:6] == 2'b00 && op_i[3:0] == 4'h9) begin
                            dec_o.rule = RL_PLUS1;
                            dec_o.src  = SRC_HL;
                        end else if (op_i[7:6] == 2'b11 && op_i[2:0] == 3'd7) begin
                            dec_o.rule = RL_RST;
                        end else if (op_i[7:6] == 2'b11 &&
                                     (op_i[2:0] == 3'd2 || op_i[2:0] == 3'd4)) begin
                            dec_o.rule = RL_IMM;
                        end
                    end
                endcase
            end
            PFX_ED: begin
                if (bit_page && (op_i[2:0] == 3'd3)) begin
                    dec_o.rule = RL_PLUS1;
                    dec_o.src  = SRC_IMM;
                end else if (bit_page && (op_i[2:0] == 3'd2)) begin
                    dec_o.rule = RL_PLUS1;
                    dec_o.src  = SRC_HL;
                end else begin
                    case (op_i)
                        8'h67, 8'h6F: begin dec_o.rule = RL_PLUS1; dec_o.src = SRC_HL; end
                        8'h78, 8'h79: begin dec_o.rule = RL_PLUS1; dec_o.src = SRC_BC; end
                        8'h4D:        dec_o.rule = RL_BRANCH;
                        8'hA1, 8'hB1: dec_o.rule = RL_UP;
                        8'hA9, 8'hB9: dec_o.rule = RL_DN;
                        default:      dec_o.rule = RL_KEEP;
                    endcase
                end
            end
            PFX_DD, PFX_FD: begin
                if (op_i == 8'h22 || op_i == 8'h2A) begin
                    dec_o.rule = RL_PLUS1;
                    dec_o.src  = SRC_IMM;
                end
            end
            PFX_CB: begin
                dec_o.is_bit  = bit_page;
                dec_o.bit_mem = bit_page && (op_i[2:0] == 3'd6);
            end
            PFX_IDXCB: begin
                dec_o.is_bit  = bit_page;
                dec_o.bit_mem = bit_page;
            end
            default: dec_o.rule = RL_KEEP;
        endcase
    end

endmodule

// File: rtl/hlt_next.sv
`timescale 1ns/1ps
module hlt_next
    import hlt_pkg::*;
(
    input  dec_t              dec_i,
    input  logic [ADDR_W-1:0] cur_i,
    input  logic [DATA_W-1:0] acc_i,
    input  logic [ADDR_W-1:0] bc_i,
    input  logic [ADDR_W-1:0] de_i,
    input  logic [ADDR_W-1:0] hl_i,
    input  logic [ADDR_W-1:0] imm_i,
    input  logic [ADDR_W-1:0] pc_i,
    output logic [ADDR_W-1:0] nxt_o
);

    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] base_p1;

    always_comb begin
        case (dec_i.src)
            SRC_BC:  base = bc_i;
            SRC_DE:  base = de_i;
            SRC_HL:  base = hl_i;
            default: base = imm_i;
        endcase
    end

    assign base_p1 = base + ADDR_W'(1);

    always_comb begin
        case (dec_i.rule)
            RL_PLUS1:  nxt_o = base_p1;
            RL_ACCHI:  nxt_o = {acc_i, base_p1[DATA_W-1:0]};
            RL_BRANCH: nxt_o = pc_i;
            RL_RST:    nxt_o = rst_vector(dec_i.vec);
            RL_IMM:    nxt_o = imm_i;
            RL_UP:     nxt_o = cur_i + ADDR_W'(1);
            RL_DN:     nxt_o = cur_i - ADDR_W'(1);
            default:   nxt_o = cur_i;
        endcase
    end

endmodule

// File: rtl/hlt_leak.sv
`timescale 1ns/1ps
module hlt_leak
    import hlt_pkg::*;
(
    input  dec_t              dec_i,
    input  logic [ADDR_W-1:0] latch_i,
    input  logic [DATA_W-1:0] operand_i,
    output logic [1:0]        leak_o
);

    logic [1:0] from_latch;
    logic [1:0] from_reg;

    assign from_latch = {|(latch_i & LATCH_HI_MASK), |(latch_i & LATCH_LO_MASK)};
    assign from_reg   = {|(operand_i & FLAG_HI_MASK), |(operand_i & FLAG_LO_MASK)};

    always_comb begin
        if (!dec_i.is_bit)      leak_o = 2'b00;
        else if (dec_i.bit_mem) leak_o = from_latch;
        else                    leak_o = from_reg;
    end

endmodule

// File: rtl/hidden_latch_tracker.sv
`timescale 1ns/1ps
module hidden_latch_tracker
    import hlt_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                retire,
    input  logic [PFX_W-1:0]    pfx,
    input  logic [DATA_W-1:0]   opcode,
    input  logic [ADDR_W-1:0]   imm,
    input  logic [DATA_W-1:0]   acc,
    input  logic [ADDR_W-1:0]   bc,
    input  logic [ADDR_W-1:0]   de,
    input  logic [ADDR_W-1:0]   hl,
    input  logic [ADDR_W-1:0]   new_pc,
    input  logic [DATA_W-1:0]   bit_operand,
    input  logic                preset_we,
    input  logic [ADDR_W-1:0]   preset_val,
    output logic [ADDR_W-1:0]   latch,
    output logic [1:0]          leak53
);

    dec_t              dec;
    logic [ADDR_W-1:0] latch_q;
    logic [ADDR_W-1:0] latch_nxt;

    hlt_decode u_dec (
        .pfx_i (pfx),
        .op_i  (opcode),
        .dec_o (dec)
    );

    hlt_next u_next (
        .dec_i (dec),
        .cur_i (latch_q),
        .acc_i (acc),
        .bc_i  (bc),
        .de_i  (de),
        .hl_i  (hl),
        .imm_i (imm),
        .pc_i  (new_pc),
        .nxt_o (latch_nxt)
    );

    hlt_leak u_leak (
        .dec_i     (dec),
        .latch_i   (latch_q),
        .operand_i (bit_operand),
        .leak_o    (leak53)
    );

    always_ff @(posedge clk) begin
        if (rst)            latch_q <= LATCH_RESET;
        else if (preset_we) latch_q <= preset_val;
        else if (retire)    latch_q <= latch_nxt;
    end

    assign latch = latch_q;

    AST_PRESET_WINS: assert property (@(posedge clk) disable iff (rst)
        preset_we |=> latch == $past(preset_val)); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!preset_we && !retire) |=> $stable(latch)); // R13

    AST_KEEP_RULE: assert property (@(posedge clk) disable iff (rst)
        (retire && !preset_we && dec.rule == RL_KEEP) |=> $stable(latch)); // R13

    AST_STEP_UP: assert property (@(posedge clk) disable iff (rst)
        (retire && !preset_we && dec.rule == RL_UP) |=> latch == $past(latch) + ADDR_W'(1)); // R8

    AST_STEP_DN: assert property (@(posedge clk) disable iff (rst)
        (retire && !preset_we && dec.rule == RL_DN) |=> latch == $past(latch) - ADDR_W'(1)); // R8

    AST_IMM_LOAD: assert property (@(posedge clk) disable iff (rst)
        (retire && !preset_we && dec.rule == RL_IMM) |=> latch == $past(imm)); // R11

    AST_BRANCH_PC: assert property (@(posedge clk) disable iff (rst)
        (retire && !preset_we && dec.rule == RL_BRANCH) |=> latch == $past(new_pc)); // R9

    AST_LEAK_MEM: assert property (@(posedge clk) disable iff (rst)
        (dec.is_bit && dec.bit_mem) |-> leak53 == {latch[DATA_W+FLAG_HI_POS], latch[DATA_W+FLAG_LO_POS]}); // R12

    AST_LEAK_IDLE: assert property (@(posedge clk) disable iff (rst)
        !dec.is_bit |-> leak53 == 2'b00); // R12

endmodule

// File: tb/hidden_latch_tracker_test.sv
`timescale 1ns/1ps
module hidden_latch_tracker_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        retire = 1'b0;
    logic [2:0]  pfx = 3'd0;
    logic [7:0]  opcode = 8'h00;
    logic [15:0] imm = 16'h0000;
    logic [7:0]  acc = 8'h00;
    logic [15:0] bc = 16'h0000;
    logic [15:0] de = 16'h0000;
    logic [15:0] hl = 16'h0000;
    logic [15:0] new_pc = 16'h0000;
    logic [7:0]  bit_operand = 8'h00;
    logic        preset_we = 1'b0;
    logic [15:0] preset_val = 16'h0000;
    logic [15:0] latch;
    logic [1:0]  leak53;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    hidden_latch_tracker uut (
        .clk(clk), .rst(rst), .retire(retire), .pfx(pfx), .opcode(opcode),
        .imm(imm), .acc(acc), .bc(bc), .de(de), .hl(hl), .new_pc(new_pc),
        .bit_operand(bit_operand), .preset_we(preset_we), .preset_val(preset_val),
        .latch(latch), .leak53(leak53)
    );

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic run_op(input logic [2:0] p, input logic [7:0] op);
        @(negedge clk);
        pfx = p; opcode = op; retire = 1'b1;
        @(posedge clk);
        @(negedge clk);
        retire = 1'b0;
        pfx = 3'd0; opcode = 8'h00;
    endtask

    task automatic preset(input logic [15:0] v);
        @(negedge clk);
        preset_we = 1'b1; preset_val = v;
        @(negedge clk);
        preset_we = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 reset value", latch, 16'hFFFF);
        check("R12 non-bit leak", {14'd0, leak53}, 16'd0);
    endtask

    task automatic t_preset;
        preset(16'h1234);
        check("R2 preset load", latch, 16'h1234);
        @(negedge clk);
        bc = 16'h2000; pfx = 3'd0; opcode = 8'h0A; retire = 1'b1;
        preset_we = 1'b1; preset_val = 16'h7777;
        @(negedge clk);
        retire = 1'b0; preset_we = 1'b0;
        check("R2 preset beats retire", latch, 16'h7777);
        @(negedge clk);
        @(negedge clk);
        check("R2 idle hold", latch, 16'h7777);
    endtask

    task automatic t_load_acc;
        bc = 16'h2000; run_op(3'd0, 8'h0A);
        check("R3 LD A,(BC)", latch, 16'h2001);
        de = 16'hFFFF; run_op(3'd0, 8'h1A);
        check("R3 LD A,(DE) wrap", latch, 16'h0000);
        imm = 16'h4321; run_op(3'd0, 8'h3A);
        check("R3 LD A,(nn)", latch, 16'h4322);
    endtask

    task automatic t_store_acc;
        acc = 8'h5A; bc = 16'h12FF; run_op(3'd0, 8'h02);
        check("R4 LD (BC),A carry", latch, 16'h5A00);
        de = 16'h3456; run_op(3'd0, 8'h12);
        check("R4 LD (DE),A", latch, 16'h5A57);
        acc = 8'hA5; imm = 16'h00FE; run_op(3'd0, 8'h32);
        check("R4 LD (nn),A", latch, 16'hA5FF);
    endtask

    task automatic t_word;
        imm = 16'h1000; run_op(3'd0, 8'h22);
        check("R5 LD (nn),HL", latch, 16'h1001);
        imm = 16'hFFFF; run_op(3'd1, 8'h7B);
        check("R5 ED LD SP,(nn) wrap", latch, 16'h0000);
        imm = 16'h0ABC; run_op(3'd4, 8'h2A);
        check("R5 FD LD IY,(nn)", latch, 16'h0ABD);
        imm = 16'h5550; run_op(3'd1, 8'h43);
        check("R5 ED LD (nn),BC", latch, 16'h5551);
    endtask

    task automatic t_hl;
        hl = 16'h7FFF; run_op(3'd0, 8'h39);
        check("R6 ADD HL,SP", latch, 16'h8000);
        hl = 16'h0100; run_op(3'd1, 8'h62);
        check("R6 SBC HL,HL", latch, 16'h0101);
        hl = 16'h2222; run_op(3'd1, 8'h6F);
        check("R6 RLD", latch, 16'h2223);
        hl = 16'hFFFF; run_op(3'd1, 8'h4A);
        check("R6 ADC HL,BC wrap", latch, 16'h0000);
    endtask

    task automatic t_io;
        bc = 16'hFF10; run_op(3'd1, 8'h78);
        check("R7 IN A,(C)", latch, 16'hFF11);
        bc = 16'hFFFF; run_op(3'd1, 8'h79);
        check("R7 OUT (C),A wrap", latch, 16'h0000);
    endtask

    task automatic t_block;
        preset(16'h0010);
        run_op(3'd1, 8'hA1);
        check("R8 CPI", latch, 16'h0011);
        run_op(3'd1, 8'hB1);
        check("R8 CPIR", latch, 16'h0012);
        run_op(3'd1, 8'hA9);
        check("R8 CPD", latch, 16'h0011);
        preset(16'h0000);
        run_op(3'd1, 8'hB9);
        check("R8 CPDR wrap", latch, 16'hFFFF);
    endtask

    task automatic t_branch;
        new_pc = 16'h4000; run_op(3'd0, 8'h18);
        check("R9 JR", latch, 16'h4000);
        new_pc = 16'h0102; run_op(3'd0, 8'h38);
        check("R9 JR C", latch, 16'h0102);
        new_pc = 16'hBEEF; run_op(3'd0, 8'hC9);
        check("R9 RET", latch, 16'hBEEF);
        new_pc = 16'h1357; run_op(3'd1, 8'h4D);
        check("R9 RETI", latch, 16'h1357);
    endtask

    task automatic t_rst;
        new_pc = 16'h9999;
        run_op(3'd0, 8'hFF);
        check("R10 RST 38", latch, 16'h0038);
        run_op(3'd0, 8'hC7);
        check("R10 RST 00", latch, 16'h0000);
        run_op(3'd0, 8'hD7);
        check("R10 RST 10", latch, 16'h0010);
    endtask

    task automatic t_jump;
        imm = 16'h2468; run_op(3'd0, 8'hC3);
        check("R11 JP nn", latch, 16'h2468);
        imm = 16'h1111; run_op(3'd0, 8'hDA);
        check("R11 JP C,nn", latch, 16'h1111);
        imm = 16'hCAFE; run_op(3'd0, 8'hEC);
        check("R11 CALL PE,nn", latch, 16'hCAFE);
        imm = 16'h0000; hl = 16'h8888; new_pc = 16'h8888;
        run_op(3'd0, 8'hE9);
        check("R11 JP (HL) keeps", latch, 16'hCAFE);
        run_op(3'd3, 8'hE9);
        check("R11 JP (IX) keeps", latch, 16'hCAFE);
    endtask

    task automatic t_leak;
        preset(16'h2800);
        @(negedge clk);
        pfx = 3'd2; opcode = 8'h46; bit_operand = 8'h00;
        #1 check("R12 BIT n,(HL) leak", {14'd0, leak53}, 16'd3);
        opcode = 8'h47; bit_operand = 8'h20;
        #1 check("R12 BIT n,A leak", {14'd0, leak53}, 16'd2);
        opcode = 8'h06;
        #1 check("R12 RLC (HL) no leak", {14'd0, leak53}, 16'd0);
        pfx = 3'd0; opcode = 8'h00;
        preset(16'h0800);
        @(negedge clk);
        pfx = 3'd5; opcode = 8'h7E; bit_operand = 8'hFF;
        #1 check("R12 indexed BIT leak", {14'd0, leak53}, 16'd1);
        pfx = 3'd0; opcode = 8'h00;
        run_op(3'd2, 8'h46);
        check("R13 CB page keeps", latch, 16'h0800);
        run_op(3'd5, 8'hC6);
        check("R13 indexed bit page keeps", latch, 16'h0800);
    endtask

    task automatic t_keep;
        preset(16'hA5A5);
        bc = 16'h0101; de = 16'h0202; hl = 16'h0303; imm = 16'h0404;
        new_pc = 16'h0505; acc = 8'h66;
        run_op(3'd0, 8'h00);
        check("R13 NOP keeps", latch, 16'hA5A5);
        run_op(3'd0, 8'h3E);
        check("R13 LD A,n keeps", latch, 16'hA5A5);
        run_op(3'd0, 8'h01);
        check("R13 LD BC,nn keeps", latch, 16'hA5A5);
        run_op(3'd1, 8'h44);
        check("R13 ED NEG keeps", latch, 16'hA5A5);
        run_op(3'd3, 8'h21);
        check("R13 DD LD IX,nn keeps", latch, 16'hA5A5);
        @(negedge clk);
        pfx = 3'd0; opcode = 8'h0A;
        @(negedge clk);
        @(negedge clk);
        check("R13 no retire keeps", latch, 16'hA5A5);
        opcode = 8'h00;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_preset();
        t_load_acc();
        t_store_acc();
        t_word();
        t_hl();
        t_io();
        t_block();
        t_branch();
        t_rst();
        t_jump();
        t_leak();
        t_keep();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 16'd0, 16'd1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule